// File: doc/BRIEF.md
# Selectable Clock/Buzzer Output Divider

This block produces a square wave on one output pin per channel, suitable for driving a buzzer or for exporting a clock. Each channel holds an 8-bit control byte written by software. The byte picks one of two source clocks, a fast main clock or a slow sub clock, and a power-of-two ratio. It also has an output enable bit. Both sources are seen as levels sampled in the system clock domain. Each source feeds one free-running counter that both channels share. The channel taps one bit of that counter, or the sampled source level itself for a ratio of one.

Turning a channel on or off by software takes effect only while its tap is low, so every pulse on the pin has full width. The power-mode inputs (stop, halt, the sub-clock low-power supply flag and a flag telling that the CPU runs from the sub clock) silence a channel at once, when the selected source would not be supplied. The ratio and source bits are frozen in hardware while a channel is enabled or is still running out its final high phase.

Top module: `clkbuz_out`

## Requirements
- R1: After synchronous reset both control bytes read 0x00 and both output pins are low.
- R2: Channel i's control byte is written and read at address i. Read data appears on the clock edge after the read address is presented. Bit 7 is the enable, bit 3 the source (0 main, 1 sub) and bits 2:0 the ratio code. Bits 6:4 always read 0, whatever is written.
- R3: With the main source, ratio codes 0 to 7 give an output period of 1, 2, 4, 8, 16, 2048, 4096 and 8192 main-clock periods.
- R4: With the sub source, ratio code k gives an output period of 2^k sub-clock periods (k = 0 to 7).
- R5: The output high time is exactly half its period for every ratio.
- R6: While bit 7 is 1, or the channel has not yet stopped, a write leaves bits 3:0 unchanged. Bit 7 still takes the written value.
- R7: Once a channel is disabled and has stopped, its pin stays low. A disable issued during a high phase lets that high phase finish at full length.
- R8: After an enable, the first high pulse on the pin has full length.
- R9: With the main source selected, stop mode drives the pin low by the next clock edge. Output resumes when stop is released.
- R10: With the sub source selected, stop mode does not interrupt the output while the low-power supply flag is 0. With the flag at 1, stop drives the pin low by the next edge.
- R11: With the sub source selected, the low-power supply flag at 1 together with halt mode and the CPU-on-sub flag drives the pin low. Halt with the CPU not on the sub clock lets the output run.
- R12: The two channels run independently: each keeps its own control byte and its own period while the other is reconfigured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Channel address of the write |
| wr_data | input | 8 | Control byte to write |
| rd_addr | input | AW | Channel address to read |
| rd_data | output | 8 | Registered control byte of the addressed channel |
| main_clk_lvl | input | 1 | Main source clock level, sampled by clk |
| sub_clk_lvl | input | 1 | Sub source clock level, sampled by clk |
| stop_mode | input | 1 | System is in stop mode |
| halt_mode | input | 1 | System is in halt mode |
| cpu_on_sub | input | 1 | CPU runs from the sub clock |
| sub_lp_flag | input | 1 | Sub-clock low-power supply flag |
| clk_out | output | N_CH | Divided, gated output pin per channel |

## Verification
Every ratio code of both sources is swept on channel 0, and the period and high time are measured from pin edges. This separates the non-uniform main ratio set from the plain power-of-two sub set, and it exposes any swapped or off-by-one tap. Writes during enable, and a disable issued in the middle of a long high phase, show whether the selection lock and low-phase gating work, or whether a write leaks through or a pulse is cut short. Each power-mode combination is applied with each source, so main-only stop suppression can be told apart from the flag-qualified sub-source rules. A run with both channels active at different ratios catches cross-talk between them.

// File: rtl/clkbuz_pkg.sv
package clkbuz_pkg;
  localparam int REG_W     = 8;
  localparam int CODE_W    = 3;
  // main ratio codes below MAIN_LOW_N map to 2^code, the rest jump by MAIN_JUMP
  localparam int MAIN_LOW_N = 5;
  localparam int MAIN_JUMP  = 6;
  localparam int SUB_W     = (1 << CODE_W) - 1;
  localparam int MAIN_W    = SUB_W + MAIN_JUMP;
  localparam int EXP_W     = $clog2(MAIN_W + 1);

  typedef struct packed {
    logic              en;
    logic [2:0]        zero;
    logic              src;
    logic [CODE_W-1:0] code;
  } ctl_reg_t;

  function automatic logic [EXP_W-1:0] main_exp(input logic [CODE_W-1:0] code);
    if (int'(code) < MAIN_LOW_N) return EXP_W'(code);
    return EXP_W'(int'(code) + MAIN_JUMP);
  endfunction
endpackage

// File: rtl/clkbuz_src_div.sv
module clkbuz_src_div #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         lvl,
  output logic         lvl_q,
  output logic [W-1:0] cnt
);
  logic rise;
  assign rise = lvl & ~lvl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q <= 1'b0;
      cnt   <= '0;
    end else begin
      lvl_q <= lvl;
      if (rise) cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/clkbuz_chan.sv
module clkbuz_chan
  import clkbuz_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_stb,
  input  logic [REG_W-1:0]  wr_data,
  input  logic              main_lvl,
  input  logic [MAIN_W-1:0] main_cnt,
  input  logic              sub_lvl,
  input  logic [SUB_W-1:0]  sub_cnt,
  input  logic              stop_mode,
  input  logic              halt_mode,
  input  logic              cpu_on_sub,
  input  logic              sub_lp_flag,
  output ctl_reg_t          ctl,
  output logic              pin
);
  ctl_reg_t ctl_q;
  logic act_q, pin_q, act_d, tap, supp;
  logic [MAIN_W:0] main_vec;
  logic [SUB_W:0]  sub_vec;
  logic unused_hi;

  assign unused_hi = ^wr_data[6:4];
  assign main_vec  = {main_cnt, main_lvl};
  assign sub_vec   = {sub_cnt, sub_lvl};

  always_comb begin
    if (ctl_q.src) tap = sub_vec[ctl_q.code];
    else           tap = main_vec[main_exp(ctl_q.code)];
  end

  always_comb begin
    if (ctl_q.src) supp = sub_lp_flag & (stop_mode | (halt_mode & cpu_on_sub));
    else           supp = stop_mode;
  end

  always_comb begin
    if (supp)      act_d = 1'b0;
    else if (!tap) act_d = ctl_q.en;
    else           act_d = act_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= '0;
      act_q <= 1'b0;
      pin_q <= 1'b0;
    end else begin
      if (wr_stb) begin
        ctl_q.en <= wr_data[7];
        if (!ctl_q.en && !act_q) begin
          ctl_q.src  <= wr_data[3];
          ctl_q.code <= wr_data[CODE_W-1:0];
        end
      end
      act_q <= act_d;
      pin_q <= act_d & tap;
    end
  end

  assign ctl = ctl_q;
  assign pin = pin_q;
endmodule

// File: rtl/clkbuz_out.sv
module clkbuz_out
  import clkbuz_pkg::*;
#(
  parameter  int N_CH = 2,
  localparam int AW   = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [REG_W-1:0] wr_data,
  input  logic [AW-1:0]    rd_addr,
  output logic [REG_W-1:0] rd_data,
  input  logic             main_clk_lvl,
  input  logic             sub_clk_lvl,
  input  logic             stop_mode,
  input  logic             halt_mode,
  input  logic             cpu_on_sub,
  input  logic             sub_lp_flag,
  output logic [N_CH-1:0]  clk_out
);
  logic              main_q, sub_q;
  logic [MAIN_W-1:0] main_cnt;
  logic [SUB_W-1:0]  sub_cnt;
  ctl_reg_t          ctl_arr [N_CH];
  logic [N_CH-1:0]   ctl_en, ctl_src;
  logic [REG_W-1:0]  rd_q;

  clkbuz_src_div #(.W(MAIN_W)) u_main_div (
    .clk(clk), .rst(rst), .lvl(main_clk_lvl), .lvl_q(main_q), .cnt(main_cnt));
  clkbuz_src_div #(.W(SUB_W)) u_sub_div (
    .clk(clk), .rst(rst), .lvl(sub_clk_lvl), .lvl_q(sub_q), .cnt(sub_cnt));

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    logic stb;
    assign stb = wr_en && (wr_addr == AW'(i));
    clkbuz_chan u_chan (
      .clk(clk), .rst(rst), .wr_stb(stb), .wr_data(wr_data),
      .main_lvl(main_q), .main_cnt(main_cnt),
      .sub_lvl(sub_q), .sub_cnt(sub_cnt),
      .stop_mode(stop_mode), .halt_mode(halt_mode),
      .cpu_on_sub(cpu_on_sub), .sub_lp_flag(sub_lp_flag),
      .ctl(ctl_arr[i]), .pin(clk_out[i]));
    assign ctl_en[i]  = ctl_arr[i].en;
    assign ctl_src[i] = ctl_arr[i].src;
  end

  always_ff @(posedge clk) begin
    if (rst)                     rd_q <= '0;
    else if (int'(rd_addr) < N_CH) rd_q <= ctl_arr[rd_addr];
    else                         rd_q <= '0;
  end
  assign rd_data = rd_q;
endmodule

// File: rtl/clkbuz_out_chk.sv
module clkbuz_out_chk #(
  parameter int N_CH = 2
) (
  input logic            clk,
  input logic            rst,
  input logic            stop_mode,
  input logic            halt_mode,
  input logic            cpu_on_sub,
  input logic            sub_lp_flag,
  input logic [7:0]      rd_data,
  input logic [N_CH-1:0] clk_out,
  input logic [N_CH-1:0] ctl_en,
  input logic [N_CH-1:0] ctl_src,
  input clkbuz_pkg::ctl_reg_t ctl_arr [N_CH]
);
  p_zero_bits_r2: assert property (@(posedge clk) disable iff (rst)
    rd_data[6:4] == 3'b000);

  for (genvar i = 0; i < N_CH; i++) begin : g_chk
    p_lock_r6: assert property (@(posedge clk) disable iff (rst)
      ctl_en[i] |=> $stable(ctl_arr[i].src) && $stable(ctl_arr[i].code));

    p_idle_low_r7: assert property (@(posedge clk) disable iff (rst)
      (!ctl_en[i] && $past(!ctl_en[i]) && !clk_out[i]) |=> !clk_out[i]);

    p_main_stop_r9: assert property (@(posedge clk) disable iff (rst)
      (stop_mode && !ctl_src[i]) |=> !clk_out[i]);

    p_sub_lp_stop_r10: assert property (@(posedge clk) disable iff (rst)
      (stop_mode && sub_lp_flag && ctl_src[i]) |=> !clk_out[i]);

    p_sub_halt_r11: assert property (@(posedge clk) disable iff (rst)
      (halt_mode && cpu_on_sub && sub_lp_flag && ctl_src[i]) |=> !clk_out[i]);
  end
endmodule

bind clkbuz_out clkbuz_out_chk #(.N_CH(N_CH)) u_chk (
  .clk(clk), .rst(rst), .stop_mode(stop_mode), .halt_mode(halt_mode),
  .cpu_on_sub(cpu_on_sub), .sub_lp_flag(sub_lp_flag), .rd_data(rd_data),
  .clk_out(clk_out), .ctl_en(ctl_en), .ctl_src(ctl_src), .ctl_arr(ctl_arr));

// File: tb/clkbuz_out_bench.sv
module clkbuz_out_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [0:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [0:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       main_clk_lvl = 1'b0;
  logic       sub_clk_lvl = 1'b0;
  logic       stop_mode = 1'b0, halt_mode = 1'b0, cpu_on_sub = 1'b0, sub_lp_flag = 1'b0;
  logic [1:0] clk_out;
  int checks = 0, errors = 0;
  int cyc = 0;

  localparam int MAIN_P = 2;   // main source period in clk cycles
  localparam int SUB_P  = 16;  // sub source period in clk cycles

  clkbuz_out u_clkbuz_out (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .main_clk_lvl(main_clk_lvl),
    .sub_clk_lvl(sub_clk_lvl), .stop_mode(stop_mode), .halt_mode(halt_mode),
    .cpu_on_sub(cpu_on_sub), .sub_lp_flag(sub_lp_flag), .clk_out(clk_out));

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  initial forever begin
    @(negedge clk);
    main_clk_lvl = ~main_clk_lvl;
  end
  initial forever begin
    repeat (SUB_P / 2) @(negedge clk);
    sub_clk_lvl = ~sub_clk_lvl;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete (actual hung, expected done)");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int ch, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 1'(ch); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input int ch, input logic [7:0] exp, input string tag);
    @(negedge clk);
    rd_addr = 1'(ch);
    @(negedge clk);
    chk(rd_data === exp, tag, int'(rd_data), int'(exp));
  endtask

  task automatic wait_lvl(input int ch, input logic v);
    while (clk_out[ch] !== v) @(negedge clk);
  endtask

  task automatic config_ch(input int ch, input logic [7:0] d);
    wr(ch, 8'h00);
    wait_lvl(ch, 1'b0);
    repeat (3) @(negedge clk);
    wr(ch, d);
  endtask

  // period and high time of the first full pulse
  task automatic measure(input int ch, input int per, input string tag);
    int t0, t1, t2;
    wait_lvl(ch, 1'b0);
    wait_lvl(ch, 1'b1); t0 = cyc;
    wait_lvl(ch, 1'b0); t1 = cyc;
    wait_lvl(ch, 1'b1); t2 = cyc;
    chk((t2 - t0) == per, {tag, " period"}, t2 - t0, per);
    chk((t1 - t0) == per / 2, {tag, " high time R5 R8"}, t1 - t0, per / 2);
  endtask

  task automatic low_for(input int ch, input int n, input string tag);
    int hi = 0;
    repeat (n) begin
      @(negedge clk);
      if (clk_out[ch] !== 1'b0) hi++;
    end
    chk(hi == 0, tag, hi, 0);
  endtask

  initial begin
    int t0, t1;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk(clk_out === 2'b00, "R1 outputs after reset", int'(clk_out), 0);
    rd_chk(0, 8'h00, "R1 ch0 reset byte");
    rd_chk(1, 8'h00, "R1 ch1 reset byte");
    low_for(0, 20, "R1 ch0 idle low");

    // R2 format, addressing, zero bits
    wr(0, 8'h7D);
    rd_chk(0, 8'h0D, "R2 bits 6:4 read zero");
    rd_chk(1, 8'h00, "R2 ch1 untouched by address 0");
    wr(1, 8'h73);
    rd_chk(1, 8'h03, "R2 ch1 at address 1");
    wr(1, 8'h00);

    // R3 main ratio sweep
    for (int k = 0; k < 8; k++) begin
      int e;
      e = (k < 5) ? k : k + 6;
      config_ch(0, 8'h80 | 8'(k));
      measure(0, MAIN_P << e, $sformatf("R3 main code %0d", k));
    end

    // R4 sub ratio sweep
    for (int k = 0; k < 8; k++) begin
      config_ch(0, 8'h88 | 8'(k));
      measure(0, SUB_P << k, $sformatf("R4 sub code %0d", k));
    end

    // R7 disable in mid high phase runs out full high time
    config_ch(0, 8'h8F);
    wait_lvl(0, 1'b0);
    wait_lvl(0, 1'b1); t0 = cyc;
    repeat (300) @(negedge clk);
    wr(0, 8'h0F);
    wait_lvl(0, 1'b0); t1 = cyc;
    chk((t1 - t0) == (SUB_P << 7) / 2, "R7 final high phase full", t1 - t0, (SUB_P << 7) / 2);
    low_for(0, 2100, "R7 stays low once disabled");

    // R6 lock of selection while enabled
    config_ch(0, 8'h8B);
    measure(0, SUB_P << 3, "R6 sub code 3 baseline");
    wr(0, 8'h82);
    rd_chk(0, 8'h8B, "R6 selection kept while enabled");
    measure(0, SUB_P << 3, "R6 period unchanged");
    wr(0, 8'h02);
    rd_chk(0, 8'h0B, "R6 enable cleared, selection kept");

    // R9 main source stop mode
    config_ch(0, 8'h81);
    measure(0, MAIN_P << 1, "R9 main /2 before stop");
    @(negedge clk); stop_mode = 1'b1;
    @(negedge clk);
    chk(clk_out[0] === 1'b0, "R9 low one edge after stop", int'(clk_out[0]), 0);
    low_for(0, 20, "R9 low during stop");
    stop_mode = 1'b0;
    measure(0, MAIN_P << 1, "R9 resumes after stop");

    // R10 sub source in stop
    config_ch(0, 8'h88);
    @(negedge clk); stop_mode = 1'b1;
    measure(0, SUB_P, "R10 sub runs in stop with flag 0");
    @(negedge clk); sub_lp_flag = 1'b1;
    @(negedge clk);
    chk(clk_out[0] === 1'b0, "R10 low one edge after flag", int'(clk_out[0]), 0);
    low_for(0, 40, "R10 low in stop with flag 1");
    stop_mode = 1'b0;

    // R11 sub source in halt
    halt_mode = 1'b1; cpu_on_sub = 1'b1;
    low_for(0, 40, "R11 low in halt, cpu on sub, flag 1");
    cpu_on_sub = 1'b0;
    measure(0, SUB_P, "R11 runs in halt, cpu not on sub");
    halt_mode = 1'b0; sub_lp_flag = 1'b0;

    // R12 two channels together
    config_ch(0, 8'h84);
    config_ch(1, 8'h8A);
    measure(0, MAIN_P << 4, "R12 ch0 main /16 alongside ch1");
    measure(1, SUB_P << 2, "R12 ch1 sub /4 alongside ch0");
    config_ch(1, 8'h81);
    measure(1, MAIN_P << 1, "R12 ch1 main /2");
    measure(0, MAIN_P << 4, "R12 ch0 kept after ch1 reconfig");
    rd_chk(0, 8'h84, "R12 ch0 byte kept");
    rd_chk(1, 8'h81, "R12 ch1 byte");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule